// File: doc/BRIEF.md
# Quasi-Resonant Valley Switching Sequencer

This block decides when the power switch of a quasi-resonant flyback converter turns on and off. Each switching cycle has an on phase and an off phase. The on phase ends either when the current-sense comparator reports a trip or when a maximum on-time runs out. A current trip is not acted on during a short leading-edge blanking window at the start of the on phase. The off phase starts with a minimum off interval. The length of that interval comes from the digitized feedback level: it is short under heavy load and stretches linearly as the load becomes light. When the interval ends, the block arms the valley input. It turns the gate on shortly after a valley is seen, or after a fixed timeout if no valley arrives.

At very low feedback the block enters a deep-light-load mode. A long start timer then paces the cycles and valleys are not used. The block stays in this mode until feedback climbs back past a hysteresis band. All times are counts of clock cycles and the feedback level is an unsigned integer code. The slope of the interpolation is a precomputed constant, applied with one integer multiply and a right shift. Analog sensing, the current-limit threshold and the gate driver sit outside the block.

Top module: `qr_valley_sequencer`

## Requirements
- R1: While rst_n is low, gate_out is low. After release the block behaves as if the gate had just fallen with high feedback, so the first off phase uses the short interval TMIN_FAST (or BLANK if that is larger).
- R2: With no current trip, every on phase lasts exactly TON_MAX cycles.
- R3: Number the cycles of an on phase from 0, where cycle 0 is the first cycle with gate_out high. If cs_trip is high in cycle k with k >= LEB, gate_out is low from cycle k+1 onward, so the on phase lasts k+1 cycles.
- R4: A cs_trip that is high only in cycles 0 to LEB-1 of an on phase has no effect, and that on phase runs its full length.
- R5: If fb_code >= FB_HI when the gate falls, the minimum off interval is TMIN_FAST cycles.
- R6: If FB_LO < fb_code < FB_HI when the gate falls, the interval is TMIN_FAST + (((FB_HI - fb_code) * SLOPE) >> FRAC), where SLOPE = ((TMIN_SLOW - TMIN_FAST) << FRAC) / (FB_HI - FB_LO), rounded down. If fb_code <= FB_LO and the block is not in deep-light-load mode, the interval is TMIN_SLOW. No interval is ever shorter than BLANK.
- R7: valley_in is ignored during the minimum off interval. Once the interval has ended, valley_in high in any cycle accepts a valley. The gate then rises 1 + VALLEY_DLY cycles later, so the off phase lasts interval + (cycles spent armed before the valley) + 1 + VALLEY_DLY cycles.
- R8: If no valley is accepted within TIMEOUT armed cycles, the gate rises by itself, and the off phase lasts interval + TIMEOUT cycles.
- R9: Deep-light-load mode starts in the cycle after fb_code falls below FB_LO. In this mode every off phase lasts exactly START_TIMER cycles and valley_in is ignored.
- R10: Deep-light-load mode ends only when fb_code >= FB_LO + FB_HYST. Codes from FB_LO to FB_LO + FB_HYST - 1 keep the mode on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock; all intervals are counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_code | input | FB_W | Digitized feedback level (higher means heavier load) |
| cs_trip | input | 1 | Peak-current comparator output, high when the limit is reached |
| valley_in | input | 1 | Valley detect from the auxiliary winding comparator |
| gate_out | output | 1 | Gate drive request, high during the on phase |

## Verification
Two situations are hard to reach from the ports. The first is a valley that arrives only inside the minimum off interval. The second is a feedback code inside the hysteresis band, reached from the deep-light-load side. For the first, the stimulus waits for an observed falling edge of gate_out and counts clock edges from it. It then drops a one-cycle valley pulse either into the blanked interval or a known number of cycles into the armed window, and checks the resulting off length. For the second, feedback is first pulled below FB_LO so that the mode is entered. It is then raised to codes just below and exactly at the exit level, and the off length shows whether the start timer or the interpolated interval is in control.

// File: rtl/qr_seq_pkg.sv
// Shared types and helpers for the quasi-resonant valley sequencer.
// Assumes nothing beyond a 2-bit phase encoding.
package qr_seq_pkg;

    // Phases of one switching cycle.
    typedef enum logic [1:0] {
        PH_ON     = 2'd0,
        PH_MINOFF = 2'd1,
        PH_ARMED  = 2'd2,
        PH_DELAY  = 2'd3
    } qr_phase_e;

    // Larger of two integers, used when sizing counters.
    function automatic int qr_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/qr_green_detect.sv
// Deep-light-load detector with hysteresis.
// Enters the mode when the feedback code is below LO, and leaves it when the
// code reaches LO + HYST. Assumes LO + HYST fits in FB_W bits.
module qr_green_detect #(
    parameter int FB_W    = 8,
    parameter int FB_LO   = 120,
    parameter int FB_HYST = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb_code,
    output logic            green
);

    localparam logic [FB_W-1:0] ENTER_C = FB_W'(FB_LO);
    localparam logic [FB_W-1:0] EXIT_C  = FB_W'(FB_LO + FB_HYST);

    // Hysteretic mode flag, updated every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            green <= 1'b0;
        end else if (!green && (fb_code < ENTER_C)) begin
            green <= 1'b1;
        end else if (green && (fb_code >= EXIT_C)) begin
            green <= 1'b0;
        end
    end

endmodule

// File: rtl/qr_toff_calc.sv
// Minimum off-interval calculator.
// Maps the feedback code to a count of off cycles: short above FB_HI, long
// at FB_LO or below, and linear between them (one multiply and a shift).
// In deep-light-load mode it returns the start-timer length and asks the
// sequencer to skip valley detection. Assumes FB_HI > FB_LO and
// TMIN_SLOW >= TMIN_FAST.
module qr_toff_calc #(
    parameter int FB_W        = 8,
    parameter int CW          = 20,
    parameter int TMIN_FAST   = 2000,
    parameter int TMIN_SLOW   = 9500,
    parameter int BLANK       = 1000,
    parameter int START_TIMER = 525000,
    parameter int FB_HI       = 210,
    parameter int FB_LO       = 120,
    parameter int FRAC        = 8
) (
    input  logic [FB_W-1:0] fb_code,
    input  logic            green,
    output logic [CW-1:0]   off_len,
    output logic            skip_valley
);

    localparam int SLOPE = ((TMIN_SLOW - TMIN_FAST) << FRAC) / (FB_HI - FB_LO);
    localparam int SW    = $clog2(SLOPE + 1);
    localparam int PW    = FB_W + SW;

    localparam logic [FB_W-1:0] HI_C    = FB_W'(FB_HI);
    localparam logic [FB_W-1:0] LO_C    = FB_W'(FB_LO);
    localparam logic [CW-1:0]   FAST_C  = CW'(TMIN_FAST);
    localparam logic [CW-1:0]   SLOW_C  = CW'(TMIN_SLOW);
    localparam logic [CW-1:0]   BLANK_C = CW'(BLANK);
    localparam logic [CW-1:0]   START_C = CW'(START_TIMER);

    logic [FB_W-1:0] depth;
    logic [PW-1:0]   prod;
    logic [PW-1:0]   step;
    logic [CW-1:0]   raw;

    // Linear stretch: distance below FB_HI times the slope, fraction dropped.
    always_comb begin
        depth = HI_C - fb_code;
        prod  = PW'(depth) * PW'(SLOPE);
        step  = prod >> FRAC;
    end

    // Region select, blanking floor and deep-light-load override.
    always_comb begin
        if (fb_code >= HI_C) begin
            raw = FAST_C;
        end else if (fb_code <= LO_C) begin
            raw = SLOW_C;
        end else begin
            raw = FAST_C + CW'(step);
        end
        if (green) begin
            off_len     = START_C;
            skip_valley = 1'b1;
        end else begin
            off_len     = (raw < BLANK_C) ? BLANK_C : raw;
            skip_valley = 1'b0;
        end
    end

endmodule

// File: rtl/qr_phase_ctrl.sv
// Switching-cycle phase controller.
// One phase register and one shared cycle counter walk through the phases
// on, minimum off, armed and valley delay. The off interval and the
// valley-skip flag are captured at the falling edge of the gate and held
// for the whole off phase. Assumes TON_MAX > LEB, TIMEOUT >= 1 and every
// off interval >= 1.
module qr_phase_ctrl
    import qr_seq_pkg::*;
#(
    parameter int CW         = 20,
    parameter int TON_MAX    = 11250,
    parameter int LEB        = 150,
    parameter int TIMEOUT    = 2250,
    parameter int VALLEY_DLY = 50,
    parameter int RST_OFF    = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_trip,
    input  logic          valley_in,
    input  logic [CW-1:0] off_len_in,
    input  logic          skip_in,
    output logic          gate_out
);

    localparam logic [CW-1:0] TON_LAST_C = CW'(TON_MAX - 1);
    localparam logic [CW-1:0] LEB_C      = CW'(LEB);
    localparam logic [CW-1:0] TO_LAST_C  = CW'(TIMEOUT - 1);
    localparam logic [CW-1:0] DLY_LAST_C = CW'((VALLEY_DLY > 0) ? VALLEY_DLY - 1 : 0);
    localparam logic [CW-1:0] RST_C      = CW'(RST_OFF);
    localparam logic          DLY_EN     = (VALLEY_DLY > 0);

    qr_phase_e     ph, ph_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [CW-1:0] off_len, off_nxt;
    logic          skip, skip_nxt;

    // Next-phase logic for one switching cycle.
    always_comb begin
        ph_nxt   = ph;
        cnt_nxt  = cnt + CW'(1);
        off_nxt  = off_len;
        skip_nxt = skip;
        case (ph)
            PH_ON: begin
                if (((cnt >= LEB_C) && cs_trip) || (cnt == TON_LAST_C)) begin
                    ph_nxt   = PH_MINOFF;
                    cnt_nxt  = '0;
                    off_nxt  = off_len_in;
                    skip_nxt = skip_in;
                end
            end
            PH_MINOFF: begin
                if (cnt == (off_len - CW'(1))) begin
                    cnt_nxt = '0;
                    ph_nxt  = skip ? PH_ON : PH_ARMED;
                end
            end
            PH_ARMED: begin
                if (valley_in) begin
                    cnt_nxt = '0;
                    ph_nxt  = DLY_EN ? PH_DELAY : PH_ON;
                end else if (cnt == TO_LAST_C) begin
                    cnt_nxt = '0;
                    ph_nxt  = PH_ON;
                end
            end
            default: begin
                if (cnt == DLY_LAST_C) begin
                    cnt_nxt = '0;
                    ph_nxt  = PH_ON;
                end
            end
        endcase
    end

    // Phase, counter and captured off-phase settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_MINOFF;
            cnt     <= '0;
            off_len <= RST_C;
            skip    <= 1'b0;
        end else begin
            ph      <= ph_nxt;
            cnt     <= cnt_nxt;
            off_len <= off_nxt;
            skip    <= skip_nxt;
        end
    end

    assign gate_out = (ph == PH_ON);

endmodule

// File: rtl/qr_valley_sequencer.sv
// Quasi-resonant valley switching sequencer (top).
// Combines the deep-light-load detector, the off-interval calculator and the
// phase controller. All times are in clock cycles. The defaults correspond
// to a 250 MHz clock. Inputs are assumed already synchronous to clk.
module qr_valley_sequencer
    import qr_seq_pkg::*;
#(
    parameter int FB_W        = 8,
    parameter int TON_MAX     = 11250,
    parameter int LEB         = 150,
    parameter int TMIN_FAST   = 2000,
    parameter int TMIN_SLOW   = 9500,
    parameter int TIMEOUT     = 2250,
    parameter int BLANK       = 1000,
    parameter int VALLEY_DLY  = 50,
    parameter int START_TIMER = 525000,
    parameter int FB_HI       = 210,
    parameter int FB_LO       = 120,
    parameter int FB_HYST     = 10,
    parameter int FRAC        = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb_code,
    input  logic            cs_trip,
    input  logic            valley_in,
    output logic            gate_out
);

    localparam int MAXV    = qr_max(qr_max(TON_MAX, START_TIMER),
                                    qr_max(qr_max(TMIN_SLOW, TIMEOUT),
                                           qr_max(BLANK, VALLEY_DLY)));
    localparam int CW      = $clog2(MAXV + 1);
    localparam int RST_OFF = qr_max(TMIN_FAST, BLANK);

    logic          green;
    logic [CW-1:0] off_len;
    logic          skip_valley;

    qr_green_detect #(
        .FB_W   (FB_W),
        .FB_LO  (FB_LO),
        .FB_HYST(FB_HYST)
    ) green_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .fb_code(fb_code),
        .green  (green)
    );

    qr_toff_calc #(
        .FB_W       (FB_W),
        .CW         (CW),
        .TMIN_FAST  (TMIN_FAST),
        .TMIN_SLOW  (TMIN_SLOW),
        .BLANK      (BLANK),
        .START_TIMER(START_TIMER),
        .FB_HI      (FB_HI),
        .FB_LO      (FB_LO),
        .FRAC       (FRAC)
    ) toff_i (
        .fb_code    (fb_code),
        .green      (green),
        .off_len    (off_len),
        .skip_valley(skip_valley)
    );

    qr_phase_ctrl #(
        .CW        (CW),
        .TON_MAX   (TON_MAX),
        .LEB       (LEB),
        .TIMEOUT   (TIMEOUT),
        .VALLEY_DLY(VALLEY_DLY),
        .RST_OFF   (RST_OFF)
    ) phase_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_trip   (cs_trip),
        .valley_in (valley_in),
        .off_len_in(off_len),
        .skip_in   (skip_valley),
        .gate_out  (gate_out)
    );

endmodule

// File: rtl/qr_valley_sequencer_chk.sv
// Port-level checker for the valley sequencer, bound into the top module.
// It counts how long gate_out has been high or low and checks on-time
// limits, blanking, the shortest and longest off phases, and reset.
module qr_valley_sequencer_chk
    import qr_seq_pkg::*;
#(
    parameter int TON_MAX     = 11250,
    parameter int LEB         = 150,
    parameter int TMIN_FAST   = 2000,
    parameter int TMIN_SLOW   = 9500,
    parameter int TIMEOUT     = 2250,
    parameter int BLANK       = 1000,
    parameter int VALLEY_DLY  = 50,
    parameter int START_TIMER = 525000
) (
    input logic clk,
    input logic rst_n,
    input logic cs_trip,
    input logic gate_out
);

    localparam int SLOW_EFF  = qr_max(TMIN_SLOW, BLANK);
    localparam int MIN_LOW   = qr_max(TMIN_FAST, BLANK);
    localparam int LOW_LIMIT = qr_max(START_TIMER, SLOW_EFF + qr_max(TIMEOUT, 1 + VALLEY_DLY)) + 1;
    localparam int RW        = $clog2(qr_max(LOW_LIMIT, TON_MAX) + 2);

    localparam logic [RW-1:0] TON_C = RW'(TON_MAX);
    localparam logic [RW-1:0] LEB_C = RW'(LEB);
    localparam logic [RW-1:0] MINL_C = RW'(MIN_LOW);
    localparam logic [RW-1:0] LIM_C = RW'(LOW_LIMIT);

    logic [RW-1:0] hi_run;
    logic [RW-1:0] lo_run;

    // Run-length counters of the gate level, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= gate_out ? ((hi_run == TON_C) ? hi_run : hi_run + RW'(1)) : '0;
            lo_run <= gate_out ? '0 : ((lo_run == LIM_C) ? lo_run : lo_run + RW'(1));
        end
    end

    assert_reset_low_R1: assert property (@(posedge clk) !rst_n |=> !gate_out);

    assert_ontime_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gate_out |-> (hi_run < TON_C));

    assert_trip_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_out && cs_trip && (hi_run >= LEB_C)) |=> !gate_out);

    assert_leb_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_out && (hi_run < LEB_C)) |=> gate_out);

    assert_min_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_out) |-> (lo_run >= MINL_C));

    assert_off_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_out |-> (lo_run < LIM_C));

endmodule

bind qr_valley_sequencer qr_valley_sequencer_chk #(
    .TON_MAX    (TON_MAX),
    .LEB        (LEB),
    .TMIN_FAST  (TMIN_FAST),
    .TMIN_SLOW  (TMIN_SLOW),
    .TIMEOUT    (TIMEOUT),
    .BLANK      (BLANK),
    .VALLEY_DLY (VALLEY_DLY),
    .START_TIMER(START_TIMER)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_trip (cs_trip),
    .gate_out(gate_out)
);

// File: tb/qr_valley_sequencer_tb_top.sv
// Directed bench for the valley sequencer. It uses short timing parameters,
// and a negedge monitor measures the high and low run lengths of gate_out.
module qr_valley_sequencer_tb_top;

    localparam int TON_MAX = 60, LEB = 5, TMIN_FAST = 32, TMIN_SLOW = 152;
    localparam int TIMEOUT = 36, BLANK = 12, VALLEY_DLY = 2, START_TIMER = 400;
    localparam int FB_HI = 210, FB_LO = 120, FB_HYST = 10, FRAC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fb_code = 8'd230;
    logic       cs_trip = 1'b1;
    logic       valley_in = 1'b1;
    logic       gate_out;

    int  n_checks = 0, n_err = 0;
    int  rise_cnt = 0, fall_cnt = 0, run_len = 0, last_low = 0, last_high = 0;
    logic prev_gate = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    qr_valley_sequencer #(
        .FB_W(8), .TON_MAX(TON_MAX), .LEB(LEB), .TMIN_FAST(TMIN_FAST),
        .TMIN_SLOW(TMIN_SLOW), .TIMEOUT(TIMEOUT), .BLANK(BLANK),
        .VALLEY_DLY(VALLEY_DLY), .START_TIMER(START_TIMER), .FB_HI(FB_HI),
        .FB_LO(FB_LO), .FB_HYST(FB_HYST), .FRAC(FRAC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .cs_trip(cs_trip),
        .valley_in(valley_in), .gate_out(gate_out)
    );

    // Run-length monitor, sampled between clock edges.
    always @(negedge clk) begin
        if (!rst_n) begin
            run_len   = 0;
            prev_gate = 1'b0;
        end else if (gate_out != prev_gate) begin
            if (gate_out) begin last_low = run_len; rise_cnt++; end
            else begin last_high = run_len; fall_cnt++; end
            run_len   = 1;
            prev_gate = gate_out;
        end else begin
            run_len++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rises(input int n);
        int target = rise_cnt + n;
        while (rise_cnt < target) @(posedge clk);
        #1;
    endtask

    task automatic wait_falls(input int n);
        int target = fall_cnt + n;
        while (fall_cnt < target) @(posedge clk);
        #1;
    endtask

    // Expected minimum off interval, from the interpolation requirement.
    function automatic int exp_off(input int fb);
        int slope = ((TMIN_SLOW - TMIN_FAST) << FRAC) / (FB_HI - FB_LO);
        int v;
        if (fb >= FB_HI) v = TMIN_FAST;
        else if (fb <= FB_LO) v = TMIN_SLOW;
        else v = TMIN_FAST + (((FB_HI - fb) * slope) >> FRAC);
        return (v < BLANK) ? BLANK : v;
    endfunction

    task automatic t_reset_R1();
        int bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (gate_out !== 1'b0) bad++;
        end
        check("R1 gate low in reset", bad, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        wait_rises(1);
        check("R1 first off phase", last_low, TMIN_FAST + 1 + VALLEY_DLY);
    endtask

    task automatic t_trip_R3();
        fb_code = 8'd230; valley_in = 1'b1; cs_trip = 1'b1;
        wait_rises(2);
        check("R5 fast interval with valley", last_low, TMIN_FAST + 1 + VALLEY_DLY);
        wait_falls(1);
        check("R3 trip at end of blanking", last_high, LEB + 1);
    endtask

    task automatic t_cap_R2();
        cs_trip = 1'b0;
        wait_rises(2);
        wait_falls(1);
        check("R2 on-time cap", last_high, TON_MAX);
    endtask

    task automatic t_leb_R4();
        cs_trip = 1'b0;
        wait_rises(1);
        cs_trip = 1'b1;
        repeat (3) @(posedge clk);
        #1; cs_trip = 1'b0;
        wait_falls(1);
        check("R4 trip inside blanking ignored", last_high, TON_MAX);
        cs_trip = 1'b1;
    endtask

    task automatic t_interp_R6();
        int codes[5] = '{210, 200, 165, 121, 120};
        valley_in = 1'b1; cs_trip = 1'b1;
        foreach (codes[i]) begin
            fb_code = 8'(codes[i]);
            wait_rises(2);
            check($sformatf("R6 interval fb=%0d", codes[i]), last_low,
                  exp_off(codes[i]) + 1 + VALLEY_DLY);
        end
    endtask

    task automatic t_timeout_R8();
        fb_code = 8'd230; valley_in = 1'b0; cs_trip = 1'b1;
        wait_rises(2);
        check("R8 timeout restarts cycle", last_low, TMIN_FAST + TIMEOUT);
    endtask

    task automatic t_valley_R7();
        // A pulse inside the minimum off interval must be ignored.
        wait_falls(1);
        repeat (4) @(posedge clk);
        #1; valley_in = 1'b1;
        @(posedge clk); #1; valley_in = 1'b0;
        wait_rises(1);
        check("R7 valley during min-off ignored", last_low, TMIN_FAST + TIMEOUT);
        // A pulse 10 cycles into the armed window is accepted.
        wait_falls(1);
        repeat (TMIN_FAST + 10 - 1) @(posedge clk);
        #1; valley_in = 1'b1;
        @(posedge clk); #1; valley_in = 1'b0;
        wait_rises(1);
        check("R7 armed valley accepted", last_low, TMIN_FAST + 10 + 1 + VALLEY_DLY);
    endtask

    task automatic t_green_R9();
        valley_in = 1'b1; fb_code = 8'd100;
        wait_rises(2);
        check("R9 start timer governs off phase", last_low, START_TIMER);
    endtask

    task automatic t_hyst_R10();
        fb_code = 8'(FB_LO + FB_HYST - 1);
        wait_rises(2);
        check("R10 inside hysteresis band stays in mode", last_low, START_TIMER);
        fb_code = 8'(FB_LO + FB_HYST);
        wait_rises(2);
        check("R10 exit at band top", last_low, exp_off(FB_LO + FB_HYST) + 1 + VALLEY_DLY);
    endtask

    initial begin
        t_reset_R1();
        t_trip_R3();
        t_cap_R2();
        t_leb_R4();
        t_interp_R6();
        t_timeout_R8();
        t_valley_R7();
        t_green_R9();
        t_hyst_R10();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule